// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block moves a stream of data words from one clock domain to another clock domain whose phase and frequency bear no fixed relation to the first. A producer writes words with a write enable on the write clock and watches a full flag. A consumer pulls words with a read enable on the read clock and watches an empty flag. Words leave in the order they entered. Each domain has its own active-low reset.

Storage is a 256-entry register array used as a ring: both pointers start at address 0 and wrap from 255 back to 0. Each side keeps its pointer in binary for addressing and also as a registered Gray code. The Gray value crosses to the other domain through a two-flop synchronizer on every bit. Because the copy of the far pointer can lag, the flags are pessimistic. The write side reports full once its pointer sits one slot behind the synchronized read pointer, so at most 255 words are held. The read side reports empty as soon as its pointer meets the synchronized write pointer.

Each side is a two-state machine whose state register is the flag itself. On the write side, W_OPEN accepts writes. It moves to W_FULL ("fill") when the pointer after this cycle's write would sit one slot behind the synchronized read pointer. W_FULL returns to W_OPEN ("release") once the synchronized read pointer has moved on. On the read side, R_EMPTY refuses reads. It moves to R_HOLD ("arrive") when the synchronized write pointer differs from the read pointer. R_HOLD falls back to R_EMPTY ("drain") when the pointer after this cycle's read equals the synchronized write pointer.

Top module: `async_fifo_dc`

## Requirements
- R1: After each domain's reset, wr_full is 0 and rd_empty is 1. Both pointers restart at address 0.
- R2: Words come out on rd_data in exactly the order in which accepted writes took them in.
- R3: A write presented while wr_full is 1 is dropped. It stores nothing and does not move the write pointer, so the word never appears at rd_data.
- R4: A read presented while rd_empty is 1 is dropped. It does not move the read pointer, and rd_data keeps its value.
- R5: With no reads, wr_full is 0 after each of the first 254 writes. It is 1 at the first write-clock edge following the 255th write, so the usable depth is 255.
- R6: rd_data is registered. It shows the word of an accepted read right after the read-clock edge that accepts the read, and it holds that word until the next accepted read.
- R7: rd_empty rises at the same read-clock edge that accepts the read of the last stored word. It stays 0 while at least one word is known to be stored.
- R8: Both pointers wrap from 255 to 0 without breaking order. A stream longer than 256 words is delivered intact.
- R9: The Gray pointer that each side sends to the other domain changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| wrst_n | input | 1 | Write-domain reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Registered full flag, write domain |
| rclk | input | 1 | Read-domain clock |
| rrst_n | input | 1 | Read-domain reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| rd_empty | output | 1 | Registered empty flag, read domain |

## Verification
A write pointer that steps twice or misses a step shows up as a swapped, repeated or missing word. It appears at the first read that reaches the bad slot, which can be up to 255 words later. A flag machine stuck in the wrong state shows right away at the flag port. A flag that fires one slot early or late is seen at the 255th fill write, or at the read of the last word. The bench therefore scores every word against a queue and samples both flags at the edge where they must change. It also probes a full FIFO and an empty FIFO with requests that must be dropped.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    typedef enum logic {
        W_OPEN = 1'b0,
        W_FULL = 1'b1
    } wr_state_e;

    typedef enum logic {
        R_EMPTY = 1'b0,
        R_HOLD  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[b] <= 1'b0;
                stage2[b] <= 1'b0;
            end else begin
                stage1[b] <= d[b];
                stage2[b] <= stage1[b];
            end
        end
    end

    assign q = stage2;

endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= cells[raddr];
        end
    end

    assign rdata = rdata_q;

    // R6: output word only changes on an accepted read
    p_rdata_hold_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
        !re |=> $stable(rdata));

endmodule

// File: rtl/afifo_wr_ctrl.sv
module afifo_wr_ctrl
    import afifo_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] rgray_s,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] wgray,
    output logic          wfull,
    output logic          wr_do
);

    wr_state_e     state_q, state_d;
    logic [AW-1:0] wbin_q;
    logic [AW-1:0] wbin_nxt;
    logic [AW-1:0] wgray_q;
    logic [AW-1:0] rbin_s;

    function automatic logic [AW-1:0] to_gray(input logic [AW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [AW-1:0] from_gray(input logic [AW-1:0] g);
        logic [AW-1:0] b;
        b[AW-1] = g[AW-1];
        for (int i = AW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // output process
    always_comb begin
        wr_do    = wr_en && (state_q == W_OPEN);
        wbin_nxt = wbin_q + AW'(wr_do);
        rbin_s   = from_gray(rgray_s);
        wfull    = (state_q == W_FULL);
        waddr    = wbin_q;
        wgray    = wgray_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_OPEN: state_d = ((wbin_nxt + AW'(1)) == rbin_s) ? W_FULL : W_OPEN;
            W_FULL: state_d = ((wbin_q + AW'(1)) == rbin_s) ? W_FULL : W_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            state_q <= W_OPEN;
            wbin_q  <= '0;
            wgray_q <= '0;
        end else begin
            state_q <= state_d;
            wbin_q  <= wbin_nxt;
            wgray_q <= to_gray(wbin_nxt);
        end
    end

    // R3: a write against a full FIFO leaves the pointer where it was
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wfull && wr_en) |=> $stable(waddr));

    // R9: the pointer sent across changes by at most one bit
    p_wgray_step_r9: assert property (@(posedge wclk) disable iff (!wrst_n)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

endmodule

// File: rtl/afifo_rd_ctrl.sv
module afifo_rd_ctrl
    import afifo_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] wgray_s,
    output logic [AW-1:0] raddr,
    output logic [AW-1:0] rgray,
    output logic          rempty,
    output logic          rd_do
);

    rd_state_e     state_q, state_d;
    logic [AW-1:0] rbin_q;
    logic [AW-1:0] rbin_nxt;
    logic [AW-1:0] rgray_q;
    logic [AW-1:0] wbin_s;

    function automatic logic [AW-1:0] to_gray(input logic [AW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [AW-1:0] from_gray(input logic [AW-1:0] g);
        logic [AW-1:0] b;
        b[AW-1] = g[AW-1];
        for (int i = AW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // output process
    always_comb begin
        rd_do    = rd_en && (state_q == R_HOLD);
        rbin_nxt = rbin_q + AW'(rd_do);
        wbin_s   = from_gray(wgray_s);
        rempty   = (state_q == R_EMPTY);
        raddr    = rbin_q;
        rgray    = rgray_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_EMPTY: state_d = (rbin_q == wbin_s) ? R_EMPTY : R_HOLD;
            R_HOLD:  state_d = (rbin_nxt == wbin_s) ? R_EMPTY : R_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            state_q <= R_EMPTY;
            rbin_q  <= '0;
            rgray_q <= '0;
        end else begin
            state_q <= state_d;
            rbin_q  <= rbin_nxt;
            rgray_q <= to_gray(rbin_nxt);
        end
    end

    // R4: a read against an empty FIFO leaves the pointer where it was
    p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rempty && rd_en) |=> $stable(raddr));

    // R9: the pointer sent across changes by at most one bit
    p_rgray_step_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
        1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));

endmodule

// File: rtl/async_fifo_dc.sv
module async_fifo_dc #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    logic [ADDR_W-1:0] waddr, raddr;
    logic [ADDR_W-1:0] wgray, rgray;
    logic [ADDR_W-1:0] wgray_s, rgray_s;
    logic              wr_do, rd_do;

    afifo_wr_ctrl #(.AW(ADDR_W)) u_wr (
        .wclk    (wclk),
        .wrst_n  (wrst_n),
        .wr_en   (wr_en),
        .rgray_s (rgray_s),
        .waddr   (waddr),
        .wgray   (wgray),
        .wfull   (wr_full),
        .wr_do   (wr_do)
    );

    afifo_rd_ctrl #(.AW(ADDR_W)) u_rd (
        .rclk    (rclk),
        .rrst_n  (rrst_n),
        .rd_en   (rd_en),
        .wgray_s (wgray_s),
        .raddr   (raddr),
        .rgray   (rgray),
        .rempty  (rd_empty),
        .rd_do   (rd_do)
    );

    afifo_sync #(.W(ADDR_W)) u_w2r (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    afifo_sync #(.W(ADDR_W)) u_r2w (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    afifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk   (wclk),
        .we     (wr_do),
        .waddr  (waddr),
        .wdata  (wr_data),
        .rclk   (rclk),
        .rrst_n (rrst_n),
        .re     (rd_do),
        .raddr  (raddr),
        .rdata  (rd_data)
    );

endmodule

// File: tb/async_fifo_dc_test.sv
`timescale 1ns/1ps
module async_fifo_dc_test;

    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       wrst_n = 1'b0;
    logic       rrst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       wr_full;
    logic [7:0] rd_data;
    logic       rd_empty;

    int checks = 0;
    int errors = 0;
    int received = 0;
    bit done = 0;
    bit auto_rd = 0;
    int man_req = 0;
    bit pend = 0;
    logic [7:0] expv = '0;
    logic [7:0] exp_q[$];

    always #5 wclk = ~wclk;      // 100 MHz write clock
    always #6.85 rclk = ~rclk;   // unrelated read clock

    async_fifo_dc uut (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver: one write attempt, scoreboard updated only if it will be accepted
    task automatic wr_once(input logic [7:0] d);
        @(negedge wclk);
        wr_en = 1'b1;
        wr_data = d;
        if (!wr_full) exp_q.push_back(d);
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0 || pend) @(negedge rclk);
        repeat (4) @(negedge rclk);
    endtask

    // monitor: drives rd_en and scores every returned word
    initial begin
        forever begin
            @(negedge rclk);
            if (pend) begin
                received++;
                chk("R2 R6 R8 R9 order/data", rd_data, expv);
            end
            if (auto_rd) begin
                rd_en = ($urandom_range(0, 2) != 0);
            end else if (man_req > 0) begin
                rd_en = 1'b1;
                man_req--;
            end else begin
                rd_en = 1'b0;
            end
            pend = rd_en && !rd_empty && rrst_n;
            if (pend) begin
                if (exp_q.size() == 0) begin
                    pend = 0;
                    chk("R2 read with empty scoreboard", 1, 0);
                end else begin
                    expv = exp_q.pop_front();
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        int early_full;
        repeat (3) @(negedge wclk);
        wrst_n = 1'b1;
        repeat (3) @(negedge rclk);
        rrst_n = 1'b1;
        repeat (4) @(negedge wclk);

        // R1: reset state
        chk("R1 wr_full after reset", wr_full, 0);
        chk("R1 rd_empty after reset", rd_empty, 1);

        // R5: fill with reads stopped
        early_full = 0;
        for (int i = 0; i < 255; i++) begin
            wr_once(8'(i * 7 + 3));
            if (i < 254 && wr_full) early_full++;
            if (i == 254) chk("R5 full after 255th write", wr_full, 1);
        end
        chk("R5 full stayed low for 254 writes", early_full, 0);

        // R3: writes against full are dropped
        for (int i = 0; i < 5; i++) wr_once(8'hEE);
        chk("R3 full holds during ignored writes", wr_full, 1);
        chk("R3 scoreboard holds 255 words", exp_q.size(), 255);

        // drain
        received = 0;
        auto_rd = 1;
        wait_drain();
        auto_rd = 0;
        repeat (2) @(negedge rclk);
        chk("R3 exactly 255 words delivered", received, 255);
        chk("R7 empty after drain", rd_empty, 1);
        repeat (6) @(negedge wclk);
        chk("R5 full released after drain", wr_full, 0);

        // R4: reads against empty are dropped
        @(negedge rclk);
        held = rd_data;
        man_req = 4;
        repeat (10) @(negedge rclk);
        chk("R4 rd_data unchanged by empty reads", rd_data, held);
        chk("R4 still empty", rd_empty, 1);

        // R7: single word, empty rises at the accepting edge
        wr_once(8'hA5);
        repeat (10) @(negedge rclk);
        chk("R7 not empty with one word", rd_empty, 0);
        man_req = 1;
        wait (man_req == 0);
        @(negedge rclk);
        chk("R7 empty at edge of last read", rd_empty, 1);
        chk("R6 word visible one edge after read", rd_data, 8'hA5);
        repeat (3) @(negedge rclk);

        // R8: long random stream across pointer wrap
        received = 0;
        auto_rd = 1;
        for (int i = 0; i < 600; i++) begin
            repeat ($urandom_range(0, 1)) @(negedge wclk);
            wr_once(8'($urandom_range(0, 255)));
        end
        wait_drain();
        auto_rd = 0;
        chk("R8 all stream words delivered", received, 600);
        chk("R8 scoreboard empty", exp_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule